// File: doc/BRIEF.md
# Serial Channel Data Register Port

This block is the processor-side data register of one serial controller channel. It fronts a small receive queue, which a receive engine fills one character per cycle, and a transmit queue, which a transmit engine drains one character per cycle. The processor sees one data register at two byte addresses, a low one and a high one. A read takes received characters out of the receive queue. A write places characters into the transmit queue.

A static mode input selects how the processor bus behaves. In word mode a word read can take two characters in one access, and a word write can load two. In byte mode every access is treated as a single-byte access at the address it names. The block raises a receive-ready flag while characters are waiting and a transmit-ready flag while the transmit queue has room. It reports how many characters each read consumed. A receive character that arrives when the queue is full is dropped and sets a sticky overrun flag.

Read results are registered. The data and the consumed count for a read strobe appear on the outputs after the next rising clock edge. The data lanes hold their value until the next read.

Top module: `sio_dbuf_port`

## Requirements
- R1: A byte read takes the oldest receive character and removes it. At the low address (`cpu_hi_i`=0) the character appears on bits 7:0 with bits 15:8 zero. At the high address it appears on bits 15:8 with bits 7:0 zero. `rd_cnt_o` reports 1.
- R2: In word mode (`bus_mode_i`=0), a word read with two or more characters queued returns the oldest on bits 7:0 and the next on bits 15:8. It removes both, and `rd_cnt_o` reports 2.
- R3: In word mode, a word read with exactly one character queued returns it on bits 7:0 with bits 15:8 zero. It removes only that character, and `rd_cnt_o` reports 1.
- R4: A read of an empty receive queue returns all-zero data and `rd_cnt_o`=0. Characters pushed afterwards are read back in arrival order.
- R5: In byte mode (`bus_mode_i`=1), `cpu_word_i` has no effect. Every read acts as the byte read of R1 at the addressed lane.
- R6: A byte write pushes one transmit character. At the low address it takes bits 7:0 of `cpu_wdata_i`; at the high address it takes bits 15:8.
- R7: In word mode, a word write pushes bits 7:0 and then bits 15:8. Each is pushed only if a slot is free. In byte mode a word write pushes only the addressed lane.
- R8: A write while the transmit queue is full is discarded, and the queued characters stay intact and in order.
- R9: `rxrdy_o` is high exactly when the receive queue is non-empty. `txrdy_o` is high exactly when the transmit queue has a free slot.
- R10: A receive push into a full queue that is not read in the same cycle is dropped and sets `rx_ovr_o`. The flag stays set until `ovr_clr_i` is pulsed.
- R11: A receive push and a read in the same cycle are both honoured. The read returns the contents from before the push, so a full queue being read accepts the push without overrun.
- R12: `cpu_rdata_o` and `rd_cnt_o` update on the clock edge that samples `cpu_rd_i`. `rd_cnt_o` returns to 0 after a cycle without a read, while `cpu_rdata_o` holds.
- R13: `tx_vld_o` is high while the transmit queue is non-empty. `tx_data_o` shows the oldest transmit character, and `tx_pop_i` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | 0 word mode, 1 byte mode |
| cpu_rd_i | input | 1 | Read strobe, one cycle per access |
| cpu_wr_i | input | 1 | Write strobe, one cycle per access |
| cpu_hi_i | input | 1 | Byte address select, 1 selects the high byte |
| cpu_word_i | input | 1 | Word access when set |
| cpu_wdata_i | input | 16 | Write data, two byte lanes |
| cpu_rdata_o | output | 16 | Registered read data |
| rd_cnt_o | output | 2 | Characters consumed by the previous cycle's read |
| rxrdy_o | output | 1 | Receive queue non-empty |
| txrdy_o | output | 1 | Transmit queue has a free slot |
| rx_push_i | input | 1 | Receive engine delivers a character |
| rx_data_i | input | 8 | Delivered character |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_ovr_o | output | 1 | Sticky receive overrun |
| tx_pop_i | input | 1 | Transmit engine takes the head character |
| tx_data_o | output | 8 | Head of the transmit queue |
| tx_vld_o | output | 1 | Transmit queue non-empty |

## Verification
Read data and consumed count are due one clock edge after the read strobe. The ready flags, the overrun flag and the transmit head follow the edge that moves the queue. All of these are due at the same edge. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. The sweep covers both modes, every fill level from empty to full and all three access kinds, with expected characters computed from a running sequence number. After each read it drains the queue to confirm what remains, so the effect of an access on the queue is seen at the ports.

// File: rtl/sio_dbuf_pkg.sv
package sio_dbuf_pkg;

  typedef enum logic {
    BUS_WORD = 1'b0,
    BUS_BYTE = 1'b1
  } bus_mode_e;

  typedef logic [1:0] xfer_cnt_t;

  localparam xfer_cnt_t XFER_NONE = 2'd0;
  localparam xfer_cnt_t XFER_ONE  = 2'd1;
  localparam xfer_cnt_t XFER_TWO  = 2'd2;

endpackage

// File: rtl/sio_dbuf_fifo.sv
// Queue that accepts up to two pushes and serves up to two pops per cycle.
// DEPTH must be a power of two, at least 2.
module sio_dbuf_fifo
  import sio_dbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xfer_cnt_t     push_n_i,
  input  logic [DW-1:0] push_d0_i,
  input  logic [DW-1:0] push_d1_i,
  input  xfer_cnt_t     pop_n_i,
  output logic [DW-1:0] head0_o,
  output logic [DW-1:0] head1_o,
  output logic [CW-1:0] count_o,
  output xfer_cnt_t     push_acc_o,
  output xfer_cnt_t     pop_acc_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, wr_ptr1;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d, rd_ptr1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pop_ext, push_ext;
  logic [CW:0]   free_slots;
  xfer_cnt_t     pop_acc, push_acc;

  assign pop_ext  = CW'(pop_n_i);
  assign push_ext = CW'(push_n_i);

  // Pops are limited by what is stored before this cycle's pushes.
  always_comb begin
    if (cnt_q >= pop_ext) pop_acc = pop_n_i;
    else                  pop_acc = xfer_cnt_t'(cnt_q);
  end

  // A slot freed by a pop in the same cycle may take a push.
  assign free_slots = (CW+1)'(DEPTH) - (CW+1)'(cnt_q) + (CW+1)'(pop_acc);

  always_comb begin
    if ((CW+1)'(push_ext) <= free_slots) push_acc = push_n_i;
    else                                 push_acc = xfer_cnt_t'(free_slots);
  end

  assign wr_ptr1 = wr_ptr_q + AW'(1);
  assign rd_ptr1 = rd_ptr_q + AW'(1);

  // Storage: one write port per slot, no reset on data.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we0, we1;
    assign we0 = (push_acc != XFER_NONE) && (wr_ptr_q == AW'(i));
    assign we1 = (push_acc == XFER_TWO)  && (wr_ptr1  == AW'(i));
    always_ff @(posedge clk) begin
      if (we0)      mem[i] <= push_d0_i;
      else if (we1) mem[i] <= push_d1_i;
    end
  end

  // Next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q + AW'(push_acc);
    rd_ptr_d = rd_ptr_q + AW'(pop_acc);
    cnt_d    = cnt_q + CW'(push_acc) - CW'(pop_acc);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign head0_o    = mem[rd_ptr_q];
  assign head1_o    = mem[rd_ptr1];
  assign count_o    = cnt_q;
  assign push_acc_o = push_acc;
  assign pop_acc_o  = pop_acc;

endmodule

// File: rtl/sio_dbuf_rdctl.sv
// Decodes processor reads into pop requests and forms the registered result.
module sio_dbuf_rdctl
  import sio_dbuf_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_mode_e     mode_i,
  input  logic          rd_i,
  input  logic          word_i,
  input  logic          hi_i,
  input  logic [DW-1:0] head0_i,
  input  logic [DW-1:0] head1_i,
  input  xfer_cnt_t     pop_acc_i,
  output xfer_cnt_t     pop_req_o,
  output logic [BW-1:0] rdata_o,
  output xfer_cnt_t     rd_cnt_o
);

  logic          word_rd;
  logic [DW-1:0] lane_lo, lane_hi, one_ch;
  logic [BW-1:0] rdata_q, rdata_d;
  xfer_cnt_t     cnt_q, cnt_d;
  logic          rdata_en;

  assign word_rd = word_i && (mode_i == BUS_WORD);

  always_comb begin
    if (!rd_i)        pop_req_o = XFER_NONE;
    else if (word_rd) pop_req_o = XFER_TWO;
    else              pop_req_o = XFER_ONE;
  end

  // Data lanes for this cycle's read; missing characters read as zero.
  always_comb begin
    one_ch  = (pop_acc_i != XFER_NONE) ? head0_i : '0;
    lane_lo = '0;
    lane_hi = '0;
    if (word_rd) begin
      lane_lo = one_ch;
      lane_hi = (pop_acc_i == XFER_TWO) ? head1_i : '0;
    end else if (hi_i) begin
      lane_hi = one_ch;
    end else begin
      lane_lo = one_ch;
    end
  end

  // Next-state
  assign rdata_en = rd_i;
  assign rdata_d  = {lane_hi, lane_lo};
  assign cnt_d    = rd_i ? pop_acc_i : XFER_NONE;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      cnt_q   <= XFER_NONE;
    end else begin
      if (rdata_en) rdata_q <= rdata_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rd_cnt_o = cnt_q;

endmodule

// File: rtl/sio_dbuf_wrctl.sv
// Decodes processor writes into transmit pushes, low lane first.
module sio_dbuf_wrctl
  import sio_dbuf_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = 2 * DW
) (
  input  bus_mode_e     mode_i,
  input  logic          wr_i,
  input  logic          word_i,
  input  logic          hi_i,
  input  logic [BW-1:0] wdata_i,
  output xfer_cnt_t     push_n_o,
  output logic [DW-1:0] push_d0_o,
  output logic [DW-1:0] push_d1_o
);

  logic [DW-1:0] lo_lane, hi_lane;

  assign lo_lane = wdata_i[DW-1:0];
  assign hi_lane = wdata_i[BW-1:DW];

  always_comb begin
    push_n_o  = XFER_NONE;
    push_d0_o = lo_lane;
    push_d1_o = hi_lane;
    if (wr_i) begin
      if (word_i && (mode_i == BUS_WORD)) begin
        push_n_o = XFER_TWO;
      end else begin
        push_n_o  = XFER_ONE;
        push_d0_o = hi_i ? hi_lane : lo_lane;
      end
    end
  end

endmodule

// File: rtl/sio_dbuf_port.sv
module sio_dbuf_port
  import sio_dbuf_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int DW       = 8,
  localparam int BW      = 2 * DW,
  localparam int RX_CW   = $clog2(RX_DEPTH) + 1,
  localparam int TX_CW   = $clog2(TX_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_hi_i,
  input  logic          cpu_word_i,
  input  logic [BW-1:0] cpu_wdata_i,
  output logic [BW-1:0] cpu_rdata_o,
  output logic [1:0]    rd_cnt_o,
  output logic          rxrdy_o,
  output logic          txrdy_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          ovr_clr_i,
  output logic          rx_ovr_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_vld_o
);

  bus_mode_e        mode;
  xfer_cnt_t        rx_pop_req, rx_pop_acc, rx_push_acc;
  logic [DW-1:0]    rx_head0, rx_head1;
  logic [RX_CW-1:0] rx_cnt;
  xfer_cnt_t        tx_push_n, tx_push_acc, tx_pop_acc;
  logic [DW-1:0]    tx_d0, tx_d1, tx_head1;
  logic [TX_CW-1:0] tx_cnt;
  xfer_cnt_t        rd_cnt;
  logic             ovr_q, ovr_d, rx_drop;

  assign mode = bus_mode_e'(bus_mode_i);

  sio_dbuf_rdctl #(.DW(DW)) u_rdctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .rd_i      (cpu_rd_i),
    .word_i    (cpu_word_i),
    .hi_i      (cpu_hi_i),
    .head0_i   (rx_head0),
    .head1_i   (rx_head1),
    .pop_acc_i (rx_pop_acc),
    .pop_req_o (rx_pop_req),
    .rdata_o   (cpu_rdata_o),
    .rd_cnt_o  (rd_cnt)
  );

  sio_dbuf_fifo #(.DEPTH(RX_DEPTH), .DW(DW)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_n_i   ({1'b0, rx_push_i}),
    .push_d0_i  (rx_data_i),
    .push_d1_i  (rx_data_i),
    .pop_n_i    (rx_pop_req),
    .head0_o    (rx_head0),
    .head1_o    (rx_head1),
    .count_o    (rx_cnt),
    .push_acc_o (rx_push_acc),
    .pop_acc_o  (rx_pop_acc)
  );

  sio_dbuf_wrctl #(.DW(DW)) u_wrctl (
    .mode_i    (mode),
    .wr_i      (cpu_wr_i),
    .word_i    (cpu_word_i),
    .hi_i      (cpu_hi_i),
    .wdata_i   (cpu_wdata_i),
    .push_n_o  (tx_push_n),
    .push_d0_o (tx_d0),
    .push_d1_o (tx_d1)
  );

  sio_dbuf_fifo #(.DEPTH(TX_DEPTH), .DW(DW)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_n_i   (tx_push_n),
    .push_d0_i  (tx_d0),
    .push_d1_i  (tx_d1),
    .pop_n_i    ({1'b0, tx_pop_i}),
    .head0_o    (tx_data_o),
    .head1_o    (tx_head1),
    .count_o    (tx_cnt),
    .push_acc_o (tx_push_acc),
    .pop_acc_o  (tx_pop_acc)
  );

  // Overrun: next-state then register
  assign rx_drop = rx_push_i && (rx_push_acc == XFER_NONE);
  assign ovr_d   = (ovr_q && !ovr_clr_i) || rx_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign rx_ovr_o = ovr_q;
  assign rd_cnt_o = rd_cnt;
  assign rxrdy_o  = (rx_cnt != '0);
  assign txrdy_o  = (tx_cnt != TX_CW'(TX_DEPTH));
  assign tx_vld_o = (tx_cnt != '0);

endmodule

// File: rtl/sio_dbuf_port_chk.sv
module sio_dbuf_port_chk #(
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int DW       = 8,
  localparam int RX_CW   = $clog2(RX_DEPTH) + 1,
  localparam int TX_CW   = $clog2(TX_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_mode_i,
  input logic             cpu_rd_i,
  input logic             cpu_wr_i,
  input logic             cpu_word_i,
  input logic [2*DW-1:0]  cpu_rdata_o,
  input logic [1:0]       rd_cnt_o,
  input logic             rxrdy_o,
  input logic             txrdy_o,
  input logic             rx_push_i,
  input logic             ovr_clr_i,
  input logic             rx_ovr_o,
  input logic             tx_pop_i,
  input logic             tx_vld_o,
  input logic [DW-1:0]    tx_data_o,
  input logic [RX_CW-1:0] rx_cnt,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [1:0]       tx_pop_acc,
  input logic [DW-1:0]    tx_head1
);

  p_word_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_i && cpu_word_i && !bus_mode_i && (rx_cnt >= RX_CW'(2)) |=> rd_cnt_o == 2'd2);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_i && (rx_cnt == '0) |=> (rd_cnt_o == 2'd0) && (cpu_rdata_o == '0));

  p_byte_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_i && bus_mode_i |=> rd_cnt_o <= 2'd1);

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !txrdy_o && !tx_pop_i |=> !txrdy_o);

  p_rxrdy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxrdy_o) |-> $past(rx_push_i));

  p_txrdy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txrdy_o) |-> $past(cpu_wr_i));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_o && !ovr_clr_i |=> rx_ovr_o);

  p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr_o) |-> $past(rx_push_i));

  p_idle_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_i |=> rd_cnt_o == 2'd0);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_i |=> $stable(cpu_rdata_o));

  p_tx_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_i && tx_vld_o |-> tx_pop_acc == 2'd1);

  p_tx_order_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_i && (tx_cnt >= TX_CW'(2)) |=> tx_data_o == $past(tx_head1));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= RX_CW'(RX_DEPTH)) && (tx_cnt <= TX_CW'(TX_DEPTH)));

endmodule

bind sio_dbuf_port sio_dbuf_port_chk #(
  .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .DW(DW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_mode_i  (bus_mode_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_word_i  (cpu_word_i),
  .cpu_rdata_o (cpu_rdata_o),
  .rd_cnt_o    (rd_cnt_o),
  .rxrdy_o     (rxrdy_o),
  .txrdy_o     (txrdy_o),
  .rx_push_i   (rx_push_i),
  .ovr_clr_i   (ovr_clr_i),
  .rx_ovr_o    (rx_ovr_o),
  .tx_pop_i    (tx_pop_i),
  .tx_vld_o    (tx_vld_o),
  .tx_data_o   (tx_data_o),
  .rx_cnt      (rx_cnt),
  .tx_cnt      (tx_cnt),
  .tx_pop_acc  (tx_pop_acc),
  .tx_head1    (tx_head1)
);

// File: tb/sio_dbuf_port_tb_top.sv
module sio_dbuf_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_mode_i, cpu_rd_i, cpu_wr_i, cpu_hi_i, cpu_word_i;
  logic [15:0] cpu_wdata_i, cpu_rdata_o;
  logic [1:0]  rd_cnt_o;
  logic        rxrdy_o, txrdy_o, rx_push_i, ovr_clr_i, rx_ovr_o;
  logic [7:0]  rx_data_i, tx_data_o;
  logic        tx_pop_i, tx_vld_o;

  int n_vec  = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [7:0] seq = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_dbuf_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode_i),
    .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i), .cpu_hi_i(cpu_hi_i),
    .cpu_word_i(cpu_word_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o), .rd_cnt_o(rd_cnt_o),
    .rxrdy_o(rxrdy_o), .txrdy_o(txrdy_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .ovr_clr_i(ovr_clr_i), .rx_ovr_o(rx_ovr_o),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_vld_o(tx_vld_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    cpu_rd_i = 0; cpu_wr_i = 0; cpu_hi_i = 0; cpu_word_i = 0;
    rx_push_i = 0; ovr_clr_i = 0; tx_pop_i = 0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push_i = 1; rx_data_i = d;
    cyc();
    rx_push_i = 0;
  endtask

  task automatic cpu_read(input logic hi, input logic word);
    cpu_rd_i = 1; cpu_hi_i = hi; cpu_word_i = word;
    cyc();
    cpu_rd_i = 0; cpu_hi_i = 0; cpu_word_i = 0;
  endtask

  task automatic cpu_write(input logic hi, input logic word, input logic [15:0] d);
    cpu_wr_i = 1; cpu_hi_i = hi; cpu_word_i = word; cpu_wdata_i = d;
    cyc();
    cpu_wr_i = 0; cpu_hi_i = 0; cpu_word_i = 0;
  endtask

  task automatic tx_take(input string tag, input logic [7:0] exp);
    chk(tag, {15'd0, tx_vld_o}, 16'd1);
    chk(tag, {8'd0, tx_data_o}, {8'd0, exp});
    tx_pop_i = 1;
    cyc();
    tx_pop_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    idle_in();
    bus_mode_i = 0; cpu_wdata_i = '0; rx_data_i = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();

    // Reset state
    chk("R9 reset rxrdy", {15'd0, rxrdy_o}, 16'd0);
    chk("R9 reset txrdy", {15'd0, txrdy_o}, 16'd1);
    chk("R12 reset rdata", cpu_rdata_o, 16'd0);
    chk("R12 reset rd_cnt", {14'd0, rd_cnt_o}, 16'd0);
    chk("R10 reset ovr", {15'd0, rx_ovr_o}, 16'd0);
    chk("R13 reset tx_vld", {15'd0, tx_vld_o}, 16'd0);

    // Sweep: mode x fill level x access kind (0 byte low, 1 byte high, 2 word)
    for (int m = 0; m < 2; m++) begin
      for (int fill = 0; fill <= DEPTH; fill++) begin
        for (int acc = 0; acc < 3; acc++) begin
          logic [7:0] base;
          int want, n;
          logic [15:0] exp;
          bus_mode_i = m[0];
          base = seq;
          for (int i = 0; i < fill; i++) push_rx(base + 8'(i));
          seq = seq + 8'(fill);
          chk("R9 rxrdy after fill", {15'd0, rxrdy_o}, {15'd0, fill > 0});
          cpu_read(acc == 1, acc == 2);
          want = (acc == 2 && m == 0) ? 2 : 1;
          n = (want < fill) ? want : fill;
          if (n == 0)       exp = 16'h0000;
          else if (n == 2)  exp = {base + 8'd1, base};
          else if (acc == 1) exp = {base, 8'h00};
          else              exp = {8'h00, base};
          if (fill == 0)
            chk("R4 empty read data", cpu_rdata_o, exp);
          else if (n == 2)
            chk("R2 word read data", cpu_rdata_o, exp);
          else if (acc == 2 && m == 0)
            chk("R3 word read one char", cpu_rdata_o, exp);
          else if (acc == 2)
            chk("R5 byte mode word strobe", cpu_rdata_o, exp);
          else
            chk("R1 byte read data", cpu_rdata_o, exp);
          chk("R1 R2 R3 rd_cnt", {14'd0, rd_cnt_o}, 16'(n));
          cyc();
          chk("R12 idle rd_cnt", {14'd0, rd_cnt_o}, 16'd0);
          chk("R12 idle hold", cpu_rdata_o, exp);
          for (int k = n; k < fill; k++) begin
            cpu_read(0, 0);
            chk("R4 remaining order", cpu_rdata_o, {8'h00, base + 8'(k)});
          end
          chk("R9 rxrdy drained", {15'd0, rxrdy_o}, 16'd0);
        end
      end
    end

    // Overrun and simultaneous push/read
    bus_mode_i = 0;
    for (int i = 0; i < DEPTH; i++) push_rx(8'h40 + 8'(i));
    chk("R10 full no ovr", {15'd0, rx_ovr_o}, 16'd0);
    push_rx(8'h4F);
    chk("R10 ovr set", {15'd0, rx_ovr_o}, 16'd1);
    cyc();
    chk("R10 ovr sticky", {15'd0, rx_ovr_o}, 16'd1);
    ovr_clr_i = 1; cyc(); ovr_clr_i = 0;
    chk("R10 ovr cleared", {15'd0, rx_ovr_o}, 16'd0);
    rx_push_i = 1; rx_data_i = 8'h50; cpu_rd_i = 1;
    cyc();
    rx_push_i = 0; cpu_rd_i = 0;
    chk("R11 full read+push data", cpu_rdata_o, 16'h0040);
    chk("R11 full read+push no ovr", {15'd0, rx_ovr_o}, 16'd0);
    for (int k = 1; k < DEPTH; k++) begin
      cpu_read(0, 0);
      chk("R10 dropped char absent", cpu_rdata_o, {8'h00, 8'h40 + 8'(k)});
    end
    cpu_read(0, 0);
    chk("R11 pushed char last", cpu_rdata_o, 16'h0050);
    rx_push_i = 1; rx_data_i = 8'h61; cpu_rd_i = 1;
    cyc();
    rx_push_i = 0; cpu_rd_i = 0;
    chk("R11 empty read+push data", cpu_rdata_o, 16'h0000);
    chk("R11 empty read+push cnt", {14'd0, rd_cnt_o}, 16'd0);
    chk("R11 char queued", {15'd0, rxrdy_o}, 16'd1);
    cpu_read(1, 0);
    chk("R1 high address read", cpu_rdata_o, 16'h6100);

    // Transmit side, word mode
    cpu_write(0, 1, 16'hB2A1);
    cpu_write(1, 0, 16'hC3FF);
    chk("R9 txrdy one free", {15'd0, txrdy_o}, 16'd1);
    cpu_write(0, 0, 16'hEED4);
    chk("R9 txrdy full", {15'd0, txrdy_o}, 16'd0);
    cpu_write(0, 0, 16'h00EE);
    cpu_write(0, 1, 16'h7766);
    chk("R8 still full", {15'd0, txrdy_o}, 16'd0);
    tx_take("R7 word low first", 8'hA1);
    tx_take("R7 word high second", 8'hB2);
    tx_take("R6 high lane byte", 8'hC3);
    tx_take("R8 contents intact", 8'hD4);
    chk("R13 tx empty", {15'd0, tx_vld_o}, 16'd0);
    for (int i = 0; i < DEPTH - 1; i++) cpu_write(0, 0, 16'(8'h80 + 8'(i)));
    cpu_write(0, 1, 16'h2211);
    for (int i = 0; i < DEPTH - 1; i++) tx_take("R6 low lane order", 8'h80 + 8'(i));
    tx_take("R7 low pushed with one slot", 8'h11);
    chk("R7 high dropped", {15'd0, tx_vld_o}, 16'd0);

    // Transmit side, byte mode
    bus_mode_i = 1;
    cpu_write(0, 1, 16'h6655);
    cpu_write(1, 1, 16'h9988);
    tx_take("R7 byte mode word low lane", 8'h55);
    tx_take("R7 byte mode word high addr", 8'h99);
    chk("R7 byte mode single push", {15'd0, tx_vld_o}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule